// File: doc/BRIEF.md
# Bus Arbitration Read-Back Monitor

This block sits between a controller's bit engine and its line driver on a wired-AND serial bus. On this bus a dominant level is logic 0 and a recessive level is logic 1. A dominant level from any node overrides recessive levels from all the others. The bus rests recessive between frames. At the start of a frame several nodes may transmit at the same time. Each node reads the bus back at every sample point. A node that drives recessive but reads dominant has been outbid by a node with a lower identifier. It withdraws without raising any error and listens for the rest of the frame.

The monitor compares the bit it sends with the bit sampled back, but only on a sample strobe. A field flag tells it whether the current bit belongs to the contention window, which runs from the frame start bit through the last identifier bit. Inside that window, reading dominant after sending recessive is a lost contest. Outside the window, any disagreement is a bit error. Reading recessive after sending dominant is a bit error everywhere. Once a node has lost, its transmit line is forced recessive until the bus is reported idle. A node that completes the window without losing gets a single win pulse on the first sampled bit after the window.

Two nodes that send the same identifier cannot be told apart by this scheme. Assigning unique identifiers is therefore a system rule.

Top module: `arb_monitor`

## Requirements
- R1: After reset, arb_lost_o, arb_won_o, bit_err_o and rx_mode_o are 0, and tx_o equals tx_bit_i.
- R2: When sample_i=1 and arb_field_i=1 and the node is not in receive mode, tx_bit_i=1 (recessive) with rx_bit_i=0 (dominant) gives a one-cycle arb_lost_o pulse in the next cycle, and rx_mode_o goes to 1 in that same cycle. bit_err_o stays 0.
- R3: While rx_mode_o=1, tx_o is 1 whatever tx_bit_i is. No further arb_lost_o, arb_won_o or bit_err_o pulse is produced, whatever the sampled bits are.
- R4: When sample_i=1 and the node is not in receive mode, tx_bit_i=0 with rx_bit_i=1 gives a one-cycle bit_err_o pulse in the next cycle. This holds with arb_field_i at either value.
- R5: When sample_i=1, arb_field_i=0 and the node is not in receive mode, tx_bit_i=1 with rx_bit_i=0 gives a bit_err_o pulse in the next cycle. It gives no arb_lost_o pulse, and rx_mode_o stays 0.
- R6: Suppose at least one strobed bit has been taken with arb_field_i=1 since the last idle or loss, and no loss has occurred. Then the first strobed bit with arb_field_i=0 gives a one-cycle arb_won_o pulse in the next cycle. This happens once per frame and can coincide with a bit_err_o pulse.
- R7: With sample_i=0, no mismatch has any effect: all pulse outputs stay 0 and rx_mode_o keeps its value.
- R8: A cycle with bus_idle_i=1 clears receive mode and the record of the contention window, so rx_mode_o is 0 in the next cycle. A strobe in that cycle raises no pulse.
- R9: A strobed bit whose sampled value equals the sent value raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_bit_i | input | 1 | Bit the node wants to send (0 dominant, 1 recessive) |
| rx_bit_i | input | 1 | Bit sampled back from the bus |
| sample_i | input | 1 | Sample-point strobe; comparisons happen only when high |
| arb_field_i | input | 1 | High while the current bit lies in the contention window |
| bus_idle_i | input | 1 | High when the bus is idle between frames |
| tx_o | output | 1 | Line to the driver, forced recessive in receive mode |
| arb_lost_o | output | 1 | One-cycle pulse: contention lost |
| arb_won_o | output | 1 | One-cycle pulse: contention window finished without loss |
| bit_err_o | output | 1 | One-cycle pulse: read-back disagreement counted as an error |
| rx_mode_o | output | 1 | High while the node only listens after a loss |

## Verification
The win pulse and a bit error can both come from the same sample: the first bit after the contention window that is also a disagreement. The bench provokes this with a directed frame. That frame wins the window, then sends dominant and reads recessive on its first control bit. The bench expects both pulses in the next cycle. Randomized frames repeat the case, and a bench reference model judges every output cycle by cycle. A loss and a bit error must never coincide, and the random runs check this as well.

// File: rtl/arb_mon_pkg.sv
package arb_mon_pkg;

    localparam logic LVL_DOM = 1'b0;
    localparam logic LVL_REC = 1'b1;

    typedef enum logic [1:0] {
        CMP_MATCH    = 2'd0,
        CMP_SENT_REC = 2'd1,
        CMP_SENT_DOM = 2'd2
    } cmp_kind_t;

    typedef struct packed {
        logic rx_mode;
        logic seen_arb;
        logic lost_p;
        logic won_p;
        logic err_p;
    } arb_state_t;

endpackage

// File: rtl/arb_bit_compare.sv
module arb_bit_compare
    import arb_mon_pkg::*;
(
    input  logic      sent_i,
    input  logic      read_i,
    output cmp_kind_t kind_o
);

    always_comb begin
        if (sent_i == read_i)
            kind_o = CMP_MATCH;
        else if (sent_i == LVL_REC)
            kind_o = CMP_SENT_REC;
        else
            kind_o = CMP_SENT_DOM;
    end

endmodule

// File: rtl/arb_state_ctl.sv
module arb_state_ctl
    import arb_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_i,
    input  logic       arb_field_i,
    input  logic       bus_idle_i,
    input  cmp_kind_t  kind_i,
    output arb_state_t st_o
);

    arb_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.lost_p = 1'b0;
        st_d.won_p  = 1'b0;
        st_d.err_p  = 1'b0;
        if (bus_idle_i) begin
            st_d.rx_mode  = 1'b0;
            st_d.seen_arb = 1'b0;
        end else if (sample_i && !st_q.rx_mode) begin
            if (arb_field_i) begin
                if (kind_i == CMP_SENT_REC) begin
                    st_d.lost_p   = 1'b1;
                    st_d.rx_mode  = 1'b1;
                    st_d.seen_arb = 1'b0;
                end else begin
                    st_d.seen_arb = 1'b1;
                    st_d.err_p    = (kind_i == CMP_SENT_DOM);
                end
            end else begin
                st_d.err_p    = (kind_i != CMP_MATCH);
                st_d.won_p    = st_q.seen_arb;
                st_d.seen_arb = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign st_o = st_q;

    AST_LOSS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lost_p |-> $past(arb_field_i && sample_i && !bus_idle_i)); // R2
    AST_LOSS_NOT_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.lost_p && st_q.err_p)); // R2
    AST_QUIET_LISTENER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rx_mode && !st_q.lost_p) |-> !(st_q.err_p || st_q.won_p)); // R3
    AST_WON_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.won_p && st_q.lost_p)); // R6
    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err_p || st_q.won_p || st_q.lost_p) |-> $past(sample_i)); // R7
    AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_idle_i) |-> !st_q.rx_mode); // R8

endmodule

// File: rtl/arb_monitor.sv
module arb_monitor
    import arb_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_bit_i,
    input  logic rx_bit_i,
    input  logic sample_i,
    input  logic arb_field_i,
    input  logic bus_idle_i,
    output logic tx_o,
    output logic arb_lost_o,
    output logic arb_won_o,
    output logic bit_err_o,
    output logic rx_mode_o
);

    cmp_kind_t  kind;
    arb_state_t st;

    arb_bit_compare u_cmp (
        .sent_i (tx_bit_i),
        .read_i (rx_bit_i),
        .kind_o (kind)
    );

    arb_state_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample_i),
        .arb_field_i (arb_field_i),
        .bus_idle_i  (bus_idle_i),
        .kind_i      (kind),
        .st_o        (st)
    );

    assign tx_o       = st.rx_mode ? LVL_REC : tx_bit_i;
    assign arb_lost_o = st.lost_p;
    assign arb_won_o  = st.won_p;
    assign bit_err_o  = st.err_p;
    assign rx_mode_o  = st.rx_mode;

    AST_RELEASED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arb_lost_o) |-> (rx_mode_o || $past(bus_idle_i))); // R3

endmodule

// File: tb/arb_monitor_bench.sv
module arb_monitor_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_bit, rx_bit, smp, arb, idle;
    logic tx_o, lost_o, won_o, err_o, rxm_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic m_rx, m_seen;
    logic e_lost, e_won, e_err;

    always #5 clk = ~clk;

    arb_monitor u_arb_monitor (
        .clk(clk), .rst_n(rst_n), .tx_bit_i(tx_bit), .rx_bit_i(rx_bit),
        .sample_i(smp), .arb_field_i(arb), .bus_idle_i(idle),
        .tx_o(tx_o), .arb_lost_o(lost_o), .arb_won_o(won_o),
        .bit_err_o(err_o), .rx_mode_o(rxm_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic logic exp_tx(input logic t, input logic rxmode);
        return rxmode ? 1'b1 : t;
    endfunction

    // reference model of one clock step, from R2..R9
    task automatic model(input logic t, input logic r, input logic s, input logic a, input logic i);
        e_lost = 1'b0; e_won = 1'b0; e_err = 1'b0;
        if (i) begin
            m_rx = 1'b0; m_seen = 1'b0;
        end else if (s && !m_rx) begin
            if (a) begin
                if (t && !r) begin e_lost = 1'b1; m_rx = 1'b1; m_seen = 1'b0; end
                else begin e_err = !t && r; m_seen = 1'b1; end
            end else begin
                e_err = (t != r); e_won = m_seen; m_seen = 1'b0;
            end
        end
    endtask

    // drive at negedge, check tx_o before the edge, check pulses after it
    task automatic step(input string req, input logic t, input logic r, input logic s,
                        input logic a, input logic i);
        tx_bit = t; rx_bit = r; smp = s; arb = a; idle = i;
        #1;
        chk(req, "tx_o", tx_o, exp_tx(t, m_rx));
        model(t, r, s, a, i);
        @(posedge clk);
        @(negedge clk);
        chk(req, "arb_lost_o", lost_o, e_lost);
        chk(req, "arb_won_o", won_o, e_won);
        chk(req, "bit_err_o", err_o, e_err);
        chk(req, "rx_mode_o", rxm_o, m_rx);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        seed = 32'h5eed_0123;
        void'($urandom(seed));
        tx_bit = 1'b1; rx_bit = 1'b1; smp = 1'b0; arb = 1'b0; idle = 1'b1;
        m_rx = 1'b0; m_seen = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "arb_lost_o", lost_o, 1'b0);
        chk("R1", "arb_won_o", won_o, 1'b0);
        chk("R1", "bit_err_o", err_o, 1'b0);
        chk("R1", "rx_mode_o", rxm_o, 1'b0);
        tx_bit = 1'b0; #1;
        chk("R1", "tx_o", tx_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 loss: frame start matches, then send recessive, read dominant
        step("R8", 1, 1, 0, 0, 1);
        step("R9", 0, 0, 1, 1, 0);
        step("R2", 1, 0, 1, 1, 0);
        // R3 forced recessive, no further pulses
        step("R3", 0, 1, 1, 1, 0);
        step("R3", 0, 1, 1, 0, 0);
        step("R3", 1, 0, 1, 0, 0);
        // R8 idle releases, strobe in idle cycle ignored
        step("R8", 0, 1, 1, 0, 1);
        // R6 win, and win coinciding with bit error (R4)
        step("R9", 0, 0, 1, 1, 0);
        step("R9", 1, 1, 1, 1, 0);
        step("R7", 1, 0, 0, 1, 0);
        step("R6", 0, 1, 1, 0, 0);
        step("R6", 0, 0, 1, 0, 0);
        // R4 inside window
        step("R8", 1, 1, 0, 0, 1);
        step("R4", 0, 1, 1, 1, 0);
        // R5 recessive/dominant outside window is an error
        step("R6", 1, 1, 1, 0, 0);
        step("R5", 1, 0, 1, 0, 0);
        // R7 no strobe, mismatches ignored
        step("R7", 0, 1, 0, 0, 0);
        step("R7", 1, 0, 0, 1, 0);

        // randomized frames
        for (int f = 0; f < 60; f++) begin
            step("R8", 1, 1, 0, 0, 1);
            for (int b = 0; b < 24; b++) begin
                logic t, r, s, a;
                t = 1'($urandom);
                r = ($urandom % 6 == 0) ? ~t : t;
                if (!t) r = ($urandom % 8 == 0) ? 1'b1 : 1'b0;
                s = ($urandom % 4 != 0);
                a = (b < 12);
                step("R2", t, r, s, a, 1'b0);
                if (lost_o && err_o) begin
                    n_tests++; n_fail++;
                    $display("FAIL R2 loss with error actual=11 expected=10");
                end
            end
        end
        finish_run();
    end

endmodule